// File: doc/BRIEF.md
# Instruction Page Translation Bypass Register

This block sits between the fetch program counter and an instruction TLB. It keeps the most recent instruction-page translation (page number, frame number, access rights and a valid flag) in a single register. When the next fetch stays on the same page, the frame number comes straight from that register. Fetches that stay on one page therefore never wait on TLB entries whose access time has grown. Only page changes pay the longer TLB path, and each page change refills the register.

Two operating modes are selected by an input. In compare mode, every fetch starts a TLB request speculatively while the stored page number is compared against the fetch page number. On a match, the request is cancelled in the same cycle. In hint mode, a per-instruction bit supplied by the compiler decides the path, and no compare is made. A bit of 0 means "use the register" and issues no TLB request. A bit of 1 requests a fresh translation. A separate force input marks the first fetch of an interrupt or exception handler, or the first fetch after a mispredicted branch. That fetch always takes the TLB path.

The TLB is reached through a plain request/response pair with variable latency. Two event counters report how many fetches were served from the register and how many refills happened.

Top module: `last_xlat_bypass`

## Requirements
- R1: After reset the stored translation is invalid, `xlat_valid_o` is 0, both counters are 0 and `fetch_ready_o` is 1, so the first accepted fetch takes the TLB path in either mode.
- R2: The fetch page number is `fetch_pc_i[VA_W-1:PAGE_BITS]`, with PAGE_BITS 13 by default (8 KB pages) and 12 or 14 as alternatives. PC bits below PAGE_BITS never change the outcome of the compare.
- R3: In compare mode (`hint_en_i`=0), every accepted fetch raises `tlb_req_o` in the same cycle, with `tlb_vpn_o` equal to the fetch page number. `tlb_cancel_o` is raised in that same cycle exactly when the fetch is served from the register.
- R4: A fetch served from the register produces `xlat_valid_o`=1 in the next cycle, with the stored frame and access bits and `slow_o`=0, and increments `hit_count_o` by one.
- R5: A fetch on the TLB path produces no result until `tlb_rsp_valid_i`. In the cycle after the response, `xlat_valid_o`=1 with the returned frame and access bits and `slow_o`=1. The register is loaded with that translation, and `fill_count_o` increments by one. With a TLB that responds one cycle after the request, this path takes two cycles against one for a register hit.
- R6: In hint mode with hint bit 0, no force and a valid register, the fetch is served from the register even if its page differs, and `tlb_req_o` stays 0.
- R7: In hint mode with hint bit 1, the fetch takes the TLB path, as in R5.
- R8: When `force_tlb_i` is 1, the fetch takes the TLB path in either mode, even when the page numbers match, and `tlb_cancel_o` stays 0.
- R9: While a TLB response is awaited, `fetch_ready_o` is 0 and `fetch_valid_i` is ignored: no request is issued and no result is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A fetch address is presented |
| fetch_pc_i | input | VA_W | Fetch virtual address |
| hint_en_i | input | 1 | 1 selects hint mode, 0 selects compare mode |
| hint_tlb_i | input | 1 | Compiler hint for this fetch: 1 requests a TLB translation |
| force_tlb_i | input | 1 | Handler entry or post-mispredict fetch: TLB path is forced |
| fetch_ready_o | output | 1 | Block can accept a fetch this cycle |
| tlb_req_o | output | 1 | TLB lookup request |
| tlb_vpn_o | output | VA_W-PAGE_BITS | Page number to translate |
| tlb_cancel_o | output | 1 | Cancels the request raised in the same cycle |
| tlb_rsp_valid_i | input | 1 | TLB response strobe |
| tlb_rsp_pfn_i | input | PFN_W | Frame number returned by the TLB |
| tlb_rsp_prot_i | input | PROT_W | Access bits returned by the TLB |
| xlat_valid_o | output | 1 | Translation result strobe |
| xlat_pfn_o | output | PFN_W | Physical tag for the fetch |
| xlat_prot_o | output | PROT_W | Access bits for the fetch |
| slow_o | output | 1 | Result came from the TLB path |
| hit_count_o | output | CNT_W | Fetches served from the register |
| fill_count_o | output | CNT_W | Register refills |

## Verification
The checker watches, on every cycle, the handshake relations at the ports. A cancel never appears without a request, and never on a forced fetch or in hint mode. No request leaves while a response is pending. A cancelled fetch is followed one cycle later by a fast result. A response while busy is followed by a slow result carrying the returned frame. The hit counter moves only alongside a fast result. Several properties need the bench's scenarios to show them: that the right frame is returned after a sequence of page changes, that low PC bits are ignored, that a hint-0 fetch on a new page really reuses a stale translation, and that the counters reach the expected totals.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xlat_state_e;

endpackage

// File: rtl/xlat_vpn_match.sv
module xlat_vpn_match #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 13,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]  pc_i,
    input  logic             held_valid_i,
    input  logic [VPN_W-1:0] held_vpn_i,
    output logic [VPN_W-1:0] vpn_o,
    output logic             match_o
);

    assign vpn_o   = pc_i[VA_W-1:PAGE_BITS];
    assign match_o = held_valid_i && (vpn_o == held_vpn_i);

endmodule

// File: rtl/xlat_event_counter.sv
module xlat_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc_i) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/last_xlat_bypass.sv
module last_xlat_bypass
    import xlat_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 13,
    parameter int PFN_W     = 20,
    parameter int PROT_W    = 3,
    parameter int CNT_W     = 16,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [VA_W-1:0]   fetch_pc_i,
    input  logic              hint_en_i,
    input  logic              hint_tlb_i,
    input  logic              force_tlb_i,
    output logic              fetch_ready_o,
    output logic              tlb_req_o,
    output logic [VPN_W-1:0]  tlb_vpn_o,
    output logic              tlb_cancel_o,
    input  logic              tlb_rsp_valid_i,
    input  logic [PFN_W-1:0]  tlb_rsp_pfn_i,
    input  logic [PROT_W-1:0] tlb_rsp_prot_i,
    output logic              xlat_valid_o,
    output logic [PFN_W-1:0]  xlat_pfn_o,
    output logic [PROT_W-1:0] xlat_prot_o,
    output logic              slow_o,
    output logic [CNT_W-1:0]  hit_count_o,
    output logic [CNT_W-1:0]  fill_count_o
);

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
    } held_xlat_t;

    typedef struct packed {
        xlat_state_e       st;
        held_xlat_t        held;
        logic [VPN_W-1:0]  pend_vpn;
        logic              out_vld;
        logic [PFN_W-1:0]  out_pfn;
        logic [PROT_W-1:0] out_prot;
        logic              out_slow;
    } bypass_reg_t;

    bypass_reg_t r_d, r_q;

    logic [VPN_W-1:0] fetch_vpn;
    logic             page_match;
    logic             accept;
    logic             use_held;
    logic             hit_inc;
    logic             fill_inc;

    xlat_vpn_match #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_match (
        .pc_i         (fetch_pc_i),
        .held_valid_i (r_q.held.vld),
        .held_vpn_i   (r_q.held.vpn),
        .vpn_o        (fetch_vpn),
        .match_o      (page_match)
    );

    always_comb begin
        accept = fetch_valid_i && (r_q.st == ST_IDLE);
        if (hint_en_i) begin
            use_held = r_q.held.vld && !hint_tlb_i && !force_tlb_i;
        end else begin
            use_held = page_match && !force_tlb_i;
        end
        hit_inc  = accept && use_held;
        fill_inc = (r_q.st == ST_WAIT) && tlb_rsp_valid_i;

        r_d         = r_q;
        r_d.out_vld = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (use_held) begin
                        r_d.out_vld  = 1'b1;
                        r_d.out_pfn  = r_q.held.pfn;
                        r_d.out_prot = r_q.held.prot;
                        r_d.out_slow = 1'b0;
                    end else begin
                        r_d.st       = ST_WAIT;
                        r_d.pend_vpn = fetch_vpn;
                    end
                end
            end
            ST_WAIT: begin
                if (tlb_rsp_valid_i) begin
                    r_d.st        = ST_IDLE;
                    r_d.held.vld  = 1'b1;
                    r_d.held.vpn  = r_q.pend_vpn;
                    r_d.held.pfn  = tlb_rsp_pfn_i;
                    r_d.held.prot = tlb_rsp_prot_i;
                    r_d.out_vld   = 1'b1;
                    r_d.out_pfn   = tlb_rsp_pfn_i;
                    r_d.out_prot  = tlb_rsp_prot_i;
                    r_d.out_slow  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    xlat_event_counter #(.CNT_W(CNT_W)) u_hit_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (hit_inc),
        .count_o (hit_count_o)
    );

    xlat_event_counter #(.CNT_W(CNT_W)) u_fill_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (fill_inc),
        .count_o (fill_count_o)
    );

    assign fetch_ready_o = (r_q.st == ST_IDLE);
    assign tlb_req_o     = accept && (!hint_en_i || !use_held);
    assign tlb_cancel_o  = accept && !hint_en_i && use_held;
    assign tlb_vpn_o     = fetch_vpn;
    assign xlat_valid_o  = r_q.out_vld;
    assign xlat_pfn_o    = r_q.out_pfn;
    assign xlat_prot_o   = r_q.out_prot;
    assign slow_o        = r_q.out_slow;

endmodule

// File: rtl/last_xlat_bypass_chk.sv
module last_xlat_bypass_chk #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 13,
    parameter int PFN_W     = 20,
    parameter int PROT_W    = 3,
    parameter int CNT_W     = 16,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid_i,
    input logic              hint_en_i,
    input logic              force_tlb_i,
    input logic              fetch_ready_o,
    input logic              tlb_req_o,
    input logic              tlb_cancel_o,
    input logic              tlb_rsp_valid_i,
    input logic [PFN_W-1:0]  tlb_rsp_pfn_i,
    input logic              xlat_valid_o,
    input logic [PFN_W-1:0]  xlat_pfn_o,
    input logic              slow_o,
    input logic [CNT_W-1:0]  hit_count_o
);

    a_r3_req_every_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_ready_o && !hint_en_i) |-> tlb_req_o);

    a_r3_cancel_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_cancel_o |-> tlb_req_o);

    a_r4_cancel_gives_fast: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_cancel_o |=> (xlat_valid_o && !slow_o));

    a_r4_hit_count_fast_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count_o != $past(hit_count_o)) |-> (xlat_valid_o && !slow_o));

    a_r5_rsp_gives_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ready_o && tlb_rsp_valid_i) |=>
            (xlat_valid_o && slow_o && xlat_pfn_o == $past(tlb_rsp_pfn_i)));

    a_r6_no_cancel_in_hint: assert property (@(posedge clk) disable iff (!rst_n)
        hint_en_i |-> !tlb_cancel_o);

    a_r8_force_never_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        force_tlb_i |-> !tlb_cancel_o);

    a_r9_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready_o |-> !tlb_req_o);

endmodule

bind last_xlat_bypass last_xlat_bypass_chk #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .PFN_W     (PFN_W),
    .PROT_W    (PROT_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid_i   (fetch_valid_i),
    .hint_en_i       (hint_en_i),
    .force_tlb_i     (force_tlb_i),
    .fetch_ready_o   (fetch_ready_o),
    .tlb_req_o       (tlb_req_o),
    .tlb_cancel_o    (tlb_cancel_o),
    .tlb_rsp_valid_i (tlb_rsp_valid_i),
    .tlb_rsp_pfn_i   (tlb_rsp_pfn_i),
    .xlat_valid_o    (xlat_valid_o),
    .xlat_pfn_o      (xlat_pfn_o),
    .slow_o          (slow_o),
    .hit_count_o     (hit_count_o)
);

// File: tb/last_xlat_bypass_bench.sv
`timescale 1ns/1ps
module last_xlat_bypass_bench;

    localparam int VA_W   = 32;
    localparam int PGB    = 13;
    localparam int PFN_W  = 20;
    localparam int PROT_W = 3;
    localparam int CNT_W  = 16;
    localparam int VPN_W  = VA_W - PGB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid_i = 1'b0;
    logic [VA_W-1:0]   fetch_pc_i = '0;
    logic              hint_en_i = 1'b0;
    logic              hint_tlb_i = 1'b0;
    logic              force_tlb_i = 1'b0;
    logic              fetch_ready_o;
    logic              tlb_req_o;
    logic [VPN_W-1:0]  tlb_vpn_o;
    logic              tlb_cancel_o;
    logic              tlb_rsp_valid_i = 1'b0;
    logic [PFN_W-1:0]  tlb_rsp_pfn_i = '0;
    logic [PROT_W-1:0] tlb_rsp_prot_i = '0;
    logic              xlat_valid_o;
    logic [PFN_W-1:0]  xlat_pfn_o;
    logic [PROT_W-1:0] xlat_prot_o;
    logic              slow_o;
    logic [CNT_W-1:0]  hit_count_o;
    logic [CNT_W-1:0]  fill_count_o;

    always #2 clk = ~clk;

    last_xlat_bypass #(
        .VA_W(VA_W), .PAGE_BITS(PGB), .PFN_W(PFN_W), .PROT_W(PROT_W), .CNT_W(CNT_W)
    ) u_last_xlat_bypass (.*);

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
        logic              slow;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   tlb_lat = 1;
    bit   finished = 1'b0;

    logic             ref_vld = 1'b0;
    logic [VPN_W-1:0] ref_vpn = '0;
    logic [PFN_W-1:0] ref_pfn = '0;
    logic [PROT_W-1:0] ref_prot = '0;
    int hit_exp = 0;
    int fill_exp = 0;

    function automatic logic [PFN_W-1:0] tlb_pfn(input logic [VPN_W-1:0] v);
        return {1'b1, v} ^ 20'h0A5C3;
    endfunction

    function automatic logic [PROT_W-1:0] tlb_prot(input logic [VPN_W-1:0] v);
        return v[2:0] ^ 3'b101;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // TLB model: samples requests after the driver has settled its inputs
    initial begin
        @(negedge clk);
        forever begin
            #1.5;
            if (tlb_req_o && !tlb_cancel_o) begin
                logic [VPN_W-1:0] v;
                v = tlb_vpn_o;
                repeat (tlb_lat) @(negedge clk);
                tlb_rsp_valid_i = 1'b1;
                tlb_rsp_pfn_i   = tlb_pfn(v);
                tlb_rsp_prot_i  = tlb_prot(v);
                @(negedge clk);
                tlb_rsp_valid_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Monitor: pops expected results as the design produces them
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && xlat_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", {43'd0, xlat_pfn_o, 1'b0}, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(xlat_pfn_o == e.pfn, e.slow ? "R5 tlb pfn" : "R4 held pfn", 64'(xlat_pfn_o), 64'(e.pfn));
                    check(xlat_prot_o == e.prot, "R4/R5 prot", 64'(xlat_prot_o), 64'(e.prot));
                    check(slow_o == e.slow, "R5 slow flag", 64'(slow_o), 64'(e.slow));
                end
            end
        end
    end

    task automatic fetch(input logic [VA_W-1:0] pc, input bit he, input bit hb, input bit fc,
                         input int lat, input bit probe, input string tag);
        logic [VPN_W-1:0] v;
        bit use_held;
        exp_t e;
        @(negedge clk);
        while (!fetch_ready_o) @(negedge clk);
        tlb_lat       = lat;
        fetch_valid_i = 1'b1;
        fetch_pc_i    = pc;
        hint_en_i     = he;
        hint_tlb_i    = hb;
        force_tlb_i   = fc;
        v = pc[VA_W-1:PGB];
        use_held = he ? (ref_vld && !hb && !fc) : (ref_vld && !fc && v == ref_vpn);
        #1;
        check(tlb_req_o == (he ? !use_held : 1'b1), {tag, " tlb_req"}, 64'(tlb_req_o), 64'(he ? !use_held : 1'b1));
        check(tlb_cancel_o == (!he && use_held), {tag, " tlb_cancel"}, 64'(tlb_cancel_o), 64'(!he && use_held));
        if (tlb_req_o) check(tlb_vpn_o == v, "R2 tlb_vpn", 64'(tlb_vpn_o), 64'(v));
        if (use_held) begin
            e = '{pfn: ref_pfn, prot: ref_prot, slow: 1'b0};
            hit_exp++;
        end else begin
            e = '{pfn: tlb_pfn(v), prot: tlb_prot(v), slow: 1'b1};
            ref_vld = 1'b1; ref_vpn = v; ref_pfn = tlb_pfn(v); ref_prot = tlb_prot(v);
            fill_exp++;
        end
        exp_q.push_back(e);
        @(negedge clk);
        fetch_valid_i = 1'b0;
        if (probe) begin
            fetch_valid_i = 1'b1;
            fetch_pc_i    = pc ^ 32'h0010_0000;
            #1;
            check(fetch_ready_o == 1'b0, "R9 ready low while busy", 64'(fetch_ready_o), 64'd0);
            check(tlb_req_o == 1'b0, "R9 no request while busy", 64'(tlb_req_o), 64'd0);
            @(negedge clk);
            fetch_valid_i = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(fetch_ready_o == 1'b1, "R1 ready after reset", 64'(fetch_ready_o), 64'd1);
        check(xlat_valid_o == 1'b0, "R1 no result after reset", 64'(xlat_valid_o), 64'd0);
        check(hit_count_o == 0 && fill_count_o == 0, "R1 counters zero", 64'(hit_count_o), 64'd0);
        check(tlb_req_o == 1'b0, "R1 idle no request", 64'(tlb_req_o), 64'd0);

        // compare mode
        fetch(32'h0004_2000, 0, 0, 0, 1, 0, "R1 first fetch to TLB");
        fetch(32'h0004_2004, 0, 0, 0, 1, 0, "R3 same page hit");
        fetch(32'h0004_3FFC, 0, 0, 0, 1, 0, "R2 low bits ignored");
        fetch(32'h0004_4000, 0, 0, 0, 3, 1, "R5 page change miss");
        fetch(32'h0004_4100, 0, 0, 0, 1, 0, "R4 new page hit");
        fetch(32'h0004_2010, 0, 0, 0, 2, 0, "R5 back to old page");
        fetch(32'h0004_2020, 0, 0, 1, 1, 0, "R8 forced in compare mode");
        // hint mode
        fetch(32'h0123_6000, 1, 0, 0, 1, 0, "R6 hint zero reuses register");
        fetch(32'h0123_6000, 1, 1, 0, 2, 0, "R7 hint one goes to TLB");
        fetch(32'h0123_6040, 1, 0, 0, 1, 0, "R6 hint zero after refill");
        fetch(32'h0123_6080, 1, 0, 1, 1, 0, "R8 forced in hint mode");
        // back to compare mode
        fetch(32'h0123_7FF0, 0, 0, 0, 1, 0, "R3 compare hit after hint");

        @(negedge clk);
        while (!fetch_ready_o || exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        check(hit_count_o == CNT_W'(hit_exp), "R4 hit count", 64'(hit_count_o), 64'(hit_exp));
        check(fill_count_o == CNT_W'(fill_exp), "R5 fill count", 64'(fill_count_o), 64'(fill_exp));
        check(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule